// File: doc/BRIEF.md
# Mode-Selectable Video Clock Divider

This block derives three rate-related timing signals for a video encoder from one functional clock. Each is a single-cycle clock enable, and all three fire together at the start of every slow period. A one-bit mode chooses the ratios. In full mode the ratios are 1:1, 1:2 and 1:4. In reduced mode they are 1:1, 1:1 and 1:2, and the fastest enable can be switched off with a gating bit.

A data-transfer strobe paces writes into the encoder at the slowest rate. The strobe is withheld while the configuration is illegal, which is full mode with the fast enable turned off. Everything downstream is clocked by the undivided input clock and qualified by these enables.

A software reset request restarts the phase counter. While the restart runs, all enables are held low. A status flag reports when the restart has finished.

Top module: `vclk_div`

## Requirements
- R1: After hardware reset the active configuration is full mode (mode 0) with the fast enable off. `rst_done_o`=1, `cfg_err_o`=1, `ce4x_o`=0 and `strobe_o`=0. The phase counter starts at 0, so `ce1x_o`=1 and `ce2x_o`=1 in the first cycle.
- R2: In full mode (active mode 0) with the gating bit at 1, `ce4x_o` is high every cycle, `ce2x_o` every 2nd cycle and `ce1x_o` every 4th cycle.
- R3: In reduced mode (active mode 1), `ce2x_o` is high every cycle and `ce1x_o` every 2nd cycle.
- R4: `ce4x_o` is high only when the active gating bit is 1. In reduced mode, a gating bit of 0 holds `ce4x_o` low.
- R5: `cfg_err_o` is 1 exactly when the active configuration is mode 0 with the gating bit at 0. While `cfg_err_o` is 1, `strobe_o` stays 0.
- R6: `strobe_o` pulses once per slow period, in the same cycle as `ce1x_o`, whenever the configuration is legal.
- R7: `mode_i` and `en4x_i` are captured only on the clock edge that ends a slow period, or during a software reset. A change in mid-period has no effect on the outputs until the next period begins.
- R8: A 0-to-1 transition of `sw_rst_i` clears `rst_done_o` on that edge. From then on, all enables and the strobe stay low while `sw_rst_i` is 1 or the restart count is running. After that the counter resumes at phase 0, with `ce1x_o` high in the first free cycle.
- R9: `rst_done_o` returns to 1 exactly 4 clock edges after the edge that captured the rising `sw_rst_i`.
- R10: Whenever `ce1x_o` is 1, `ce2x_o` is also 1, so all outputs share the period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional input clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| mode_i | input | 1 | Requested mode: 0 full, 1 reduced |
| en4x_i | input | 1 | Requested gating bit for the fast enable |
| sw_rst_i | input | 1 | Software reset request, level: 1 reset, 0 run |
| ce4x_o | output | 1 | Fast-rate clock enable |
| ce2x_o | output | 1 | Mid-rate clock enable |
| ce1x_o | output | 1 | Slow-rate clock enable |
| strobe_o | output | 1 | Data-transfer strobe into the encoder |
| cfg_err_o | output | 1 | Illegal active configuration |
| rst_done_o | output | 1 | Software reset sequence complete |

## Verification
The bench changes mode and gating in mid-period to catch a design that applies them at once. Such a design would shorten a slow period or emit an extra `ce1x_o`. It counts enables over fixed windows in both modes, which exposes wrong ratios or a fast enable that leaks while gated. Software reset pulses are fired at random phases and held for varying lengths. A wrong restart count, a counter that does not restart at phase 0, or enables that leak during the hold would each show up as a mismatching `rst_done_o` or stray enables. It also holds the illegal full-mode configuration, where a strobe must never appear.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_HALF = 1'b1
  } vclk_mode_e;

  localparam int unsigned DIV_MAX_DEF = 4;
  localparam int unsigned RST_CYC_DEF = 4;
endpackage

// File: rtl/vclk_sw_reset.sv
module vclk_sw_reset #(
  parameter int unsigned RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_rst_i,
  output logic start_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned HOLD_W = $clog2(RST_CYC + 1);

  logic              sw_q;
  logic [HOLD_W-1:0] hold_q;
  logic              done_q;

  assign start_o = sw_rst_i & ~sw_q;
  assign busy_o  = sw_q | (hold_q != '0);
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= 1'b0;
      hold_q <= '0;
      done_q <= 1'b1;
    end else begin
      sw_q <= sw_rst_i;
      if (start_o) begin
        hold_q <= HOLD_W'(RST_CYC);
        done_q <= 1'b0;
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
        if (hold_q == HOLD_W'(1)) done_q <= 1'b1;
      end
    end
  end

  // R8
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !done_o);

  // R9
  done_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(hold_q) == HOLD_W'(1));
endmodule

// File: rtl/vclk_cfg_hold.sv
module vclk_cfg_hold
  import vclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       mode_i,
  input  logic       en4x_i,
  output vclk_mode_e mode_o,
  output logic       en4x_o
);
  vclk_mode_e mode_q;
  logic       en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_FULL;
      en_q   <= 1'b0;
    end else if (load_i) begin
      mode_q <= vclk_mode_e'(mode_i);
      en_q   <= en4x_i;
    end
  end

  assign mode_o = mode_q;
  assign en4x_o = en_q;

  // R7
  cfg_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> ($stable(mode_q) && $stable(en_q)));
endmodule

// File: rtl/vclk_phase_cnt.sv
module vclk_phase_cnt
  import vclk_pkg::*;
#(
  parameter int unsigned DIV_MAX = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  vclk_mode_e mode_i,
  input  logic       en4x_i,
  input  logic       busy_i,
  input  logic       clr_i,
  output logic       load_o,
  output logic       ce4x_o,
  output logic       ce2x_o,
  output logic       ce1x_o
);
  localparam int unsigned CNT_W     = $clog2(DIV_MAX);
  localparam int unsigned FULL_LAST = DIV_MAX - 1;
  localparam int unsigned HALF_LAST = DIV_MAX / 2 - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             wrap;
  logic             run;

  assign last   = (mode_i == MODE_HALF) ? CNT_W'(HALF_LAST) : CNT_W'(FULL_LAST);
  assign run    = ~busy_i;
  assign wrap   = run & (cnt_q == last);
  assign load_o = busy_i | clr_i | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (busy_i | clr_i | wrap) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  // period start is shared by every tap
  assign ce1x_o = run & (cnt_q == '0);
  assign ce4x_o = run & en4x_i;

  generate
    if (DIV_MAX > 2) begin : g_mid_tap
      assign ce2x_o = run & ((mode_i == MODE_HALF) | (cnt_q[CNT_W-2:0] == '0));
    end else begin : g_mid_full
      assign ce2x_o = run;
    end
  endgenerate

  // R3
  half_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HALF && !busy_i && !$past(load_o)) |-> cnt_q <= CNT_W'(HALF_LAST));
endmodule

// File: rtl/vclk_div.sv
module vclk_div
  import vclk_pkg::*;
#(
  parameter int unsigned DIV_MAX = DIV_MAX_DEF,
  parameter int unsigned RST_CYC = RST_CYC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic en4x_i,
  input  logic sw_rst_i,
  output logic ce4x_o,
  output logic ce2x_o,
  output logic ce1x_o,
  output logic strobe_o,
  output logic cfg_err_o,
  output logic rst_done_o
);
  logic       start, busy, load, act_en;
  vclk_mode_e act_mode;

  vclk_sw_reset #(.RST_CYC(RST_CYC)) i_sw_reset (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_rst_i (sw_rst_i),
    .start_o  (start),
    .busy_o   (busy),
    .done_o   (rst_done_o)
  );

  vclk_cfg_hold i_cfg_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .mode_i (mode_i),
    .en4x_i (en4x_i),
    .mode_o (act_mode),
    .en4x_o (act_en)
  );

  vclk_phase_cnt #(.DIV_MAX(DIV_MAX)) i_phase_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (act_mode),
    .en4x_i (act_en),
    .busy_i (busy),
    .clr_i  (start),
    .load_o (load),
    .ce4x_o (ce4x_o),
    .ce2x_o (ce2x_o),
    .ce1x_o (ce1x_o)
  );

  assign cfg_err_o = (act_mode == MODE_FULL) & ~act_en;
  assign strobe_o  = ce1x_o & ~cfg_err_o;

  // R10
  tap_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce1x_o |-> ce2x_o);

  // R5
  err_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !strobe_o);

  // R8
  quiet_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !(ce4x_o || ce2x_o || ce1x_o || strobe_o));
endmodule

// File: tb/test_vclk_div.sv
module test_vclk_div;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, en = 1'b0, sw = 1'b0;
  logic ce4x, ce2x, ce1x, strobe, cfg_err, done;
  int   n_chk = 0, n_bad = 0;
  bit   finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vclk_div i_vclk_div (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .en4x_i(en), .sw_rst_i(sw),
    .ce4x_o(ce4x), .ce2x_o(ce2x), .ce1x_o(ce1x), .strobe_o(strobe),
    .cfg_err_o(cfg_err), .rst_done_o(done)
  );

  // reference state built from the requirements
  logic [1:0] m_cnt;
  logic       m_mode, m_en, m_sw, m_done;
  int         m_hold;

  function automatic logic m_busy();
    return m_sw || (m_hold != 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 2'd0; m_mode <= 1'b0; m_en <= 1'b0;
      m_sw <= 1'b0; m_done <= 1'b1; m_hold <= 0;
    end else begin
      logic start, busy, wrap;
      start = sw && !m_sw;
      busy  = m_busy();
      wrap  = !busy && (m_cnt == (m_mode ? 2'd1 : 2'd3));
      m_sw <= sw;
      if (start) begin
        m_hold <= 4; m_done <= 1'b0;
      end else if (m_hold != 0) begin
        m_hold <= m_hold - 1;
        if (m_hold == 1) m_done <= 1'b1;
      end
      m_cnt <= (busy || start || wrap) ? 2'd0 : m_cnt + 2'd1;
      if (busy || start || wrap) begin
        m_mode <= mode; m_en <= en;
      end
    end
  end

  function automatic logic e_ce1x();
    return !m_busy() && (m_cnt == 2'd0);
  endfunction
  function automatic logic e_ce2x();
    return !m_busy() && (m_mode || !m_cnt[0]);
  endfunction
  function automatic logic e_ce4x();
    return !m_busy() && m_en;
  endfunction
  function automatic logic e_err();
    return !m_mode && !m_en;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // one cycle: wait to the falling edge, then compare every output
  task automatic step();
    @(negedge clk);
    chk("R2", "ce4x", ce4x, e_ce4x());
    chk("R3", "ce2x", ce2x, e_ce2x());
    chk("R6", "ce1x", ce1x, e_ce1x());
    chk("R5", "cfg_err", cfg_err, e_err());
    chk("R6", "strobe", strobe, e_ce1x() && !e_err());
    chk("R9", "done", done, m_done);
  endtask

  task automatic tally(input int n, output int c4, output int c2, output int c1, output int cs);
    c4 = 0; c2 = 0; c1 = 0; cs = 0;
    for (int i = 0; i < n; i++) begin
      step();
      c4 += int'(ce4x); c2 += int'(ce2x); c1 += int'(ce1x); cs += int'(strobe);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c4, c2, c1, cs;
    void'($urandom(32'd20240611));
    // R1 reset values
    #(CLK_P * 2 + 2);
    chk("R1", "done", done, 1'b1);
    chk("R1", "cfg_err", cfg_err, 1'b1);
    chk("R1", "ce4x", ce4x, 1'b0);
    chk("R1", "strobe", strobe, 1'b0);
    chk("R1", "ce1x", ce1x, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    step();

    // R5: illegal configuration yields no strobe
    tally(8, c4, c2, c1, cs);
    chk_int("R5", "strobes while illegal", cs, 0);
    chk_int("R1", "ce4x while gated at reset", c4, 0);

    // R2 full mode ratios
    mode = 1'b0; en = 1'b1;
    repeat (4) step();
    tally(16, c4, c2, c1, cs);
    chk_int("R2", "ce4x in 16", c4, 16);
    chk_int("R2", "ce2x in 16", c2, 8);
    chk_int("R2", "ce1x in 16", c1, 4);
    chk_int("R6", "strobe in 16", cs, 4);

    // R3/R4 reduced mode, gated
    mode = 1'b1; en = 1'b0;
    repeat (4) step();
    tally(16, c4, c2, c1, cs);
    chk_int("R4", "ce4x gated", c4, 0);
    chk_int("R3", "ce2x in 16", c2, 16);
    chk_int("R3", "ce1x in 16", c1, 8);
    chk_int("R6", "strobe reduced", cs, 8);

    // R7: change in mid-period of full mode
    mode = 1'b0; en = 1'b1;
    repeat (4) step();
    while (!ce1x) step();
    step();               // phase 1
    mode = 1'b1; en = 1'b0;
    step(); step();       // phases 2 and 3 keep full-mode taps
    chk("R7", "fast enable still on", ce4x, 1'b1);
    chk("R7", "no early slow pulse", ce1x, 1'b0);
    step();
    chk("R7", "new period start", ce1x, 1'b1);
    chk("R7", "gated after boundary", ce4x, 1'b0);

    // R8/R9 directed software reset
    sw = 1'b1;
    step();
    chk("R8", "done cleared", done, 1'b0);
    chk("R8", "enables quiet", ce2x, 1'b0);
    sw = 1'b0;
    step(); step(); step();
    chk("R9", "done still low", done, 1'b0);
    step();
    chk("R9", "done set after 4", done, 1'b1);
    chk("R8", "restart at phase 0", ce1x, 1'b1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(15) == 0) mode = ~mode;
      if ($urandom_range(11) == 0) en = ~en;
      if (sw) begin
        if ($urandom_range(3) == 0) sw = 1'b0;
      end else if ($urandom_range(63) == 0) sw = 1'b1;
      step();
    end
    sw = 1'b0;
    repeat (8) step();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule